// File: doc/BRIEF.md
# Post-Divider Clock-Enable Tree

This block takes one fast oscillator clock and derives a byte-rate and a pixel-rate timing reference from it. No new clock nets are made. Every derived rate appears as a clock-enable pulse in the oscillator domain, so downstream logic stays on the oscillator clock and qualifies its registers with the matching enable.

The tree is a cascade. A power-of-two prescaler feeds a programmable bit-rate divider. A fixed divide-by-8 tap on the bit rate gives the byte rate. Two more fixed taps give the bit rate halved and the prescaler output quartered. A 2-bit source select picks one of four intermediate rates, and a programmable pixel divider follows it. All settings live in three small fields written through a simple write port. Any write to a real field restarts every counter from zero, so a new ratio always starts from a known phase.

Top module: `postdiv_ce_tree`

## Requirements
- R1: While `rst_n` is low all four enable outputs are low. After reset the fields are: prescale exponent 0, both divider nibbles 1, and source select 0. With these values `byte_ce` repeats every 8 cycles and `stage_ce`, `bit_ce` and `pix_ce` are high every cycle.
- R2: A write to address 0 loads `wr_data[1:0]` as the prescale exponent E. `stage_ce` then pulses once every 2^E oscillator cycles.
- R3: A write to address 1 loads `wr_data[3:0]` as the one-based bit divider N. `bit_ce` then pulses once every N `stage_ce` pulses.
- R4: `byte_ce` pulses once every 8 `bit_ce` pulses.
- R5: A write to address 2 loads `wr_data[1:0]` as the pixel source. The codes are: 0 selects `bit_ce`, 1 selects `bit_ce` divided by 2, 2 selects `stage_ce`, and 3 selects `stage_ce` divided by 4.
- R6: `wr_data[7:4]` of an address-1 write is the one-based pixel divider M. `pix_ce` then pulses once every M pulses of the selected source.
- R7: A divider nibble of zero divides by 1.
- R8: When an output's overall period P is greater than 1, each of its pulses is exactly one cycle wide.
- R9: A write to address 0, 1 or 2 clears every counter at that clock edge. Counting the first cycle after the write as index 0, each output first pulses at index P-1 and then every P cycles.
- R10: A write to address 3 is ignored. No field changes and no counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 2 | Field address (0 prescale, 1 dividers, 2 source, 3 unused) |
| wr_data | input | 8 | Write data |
| stage_ce | output | 1 | Prescaler output enable |
| bit_ce | output | 1 | Bit-rate enable |
| byte_ce | output | 1 | Byte-rate enable (bit rate / 8) |
| pix_ce | output | 1 | Pixel-rate enable |

## Verification
The bench builds the block with its default parameters: a 2-bit prescale exponent, 4-bit divider nibbles, and fixed taps of 8, 2 and 4. These settings reach every prescale ratio up to 8, both zero nibbles, the largest nibble 15, and all four source codes. The longest pixel period, 1800 cycles, is measured twice over from the restart point. The bench also issues an ignored write in the middle of a long period, which shows that the phase is left alone.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    typedef enum logic [1:0] {
        SRC_BIT      = 2'd0,
        SRC_BIT_HALF = 2'd1,
        SRC_STAGE    = 2'd2,
        SRC_STAGE_QT = 2'd3
    } pix_src_e;

    typedef enum logic [1:0] {
        ADR_PRESCALE = 2'd0,
        ADR_DIVS     = 2'd1,
        ADR_SOURCE   = 2'd2,
        ADR_SPARE    = 2'd3
    } fld_adr_e;
endpackage

// File: rtl/pdt_cfg_regs.sv
module pdt_cfg_regs
    import pdt_pkg::*;
#(
    parameter int POW_W = 2,
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [2*NIB_W-1:0] wr_data,
    output logic [POW_W-1:0]   exp_q,
    output logic [NIB_W-1:0]   bit_nib_q,
    output logic [NIB_W-1:0]   pix_nib_q,
    output pix_src_e           src_q,
    output logic               restart
);
    typedef struct packed {
        logic [POW_W-1:0] expo;
        logic [NIB_W-1:0] bitn;
        logic [NIB_W-1:0] pixn;
        pix_src_e         src;
    } fld_t;

    fld_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (wr_en) begin
            unique case (fld_adr_e'(wr_addr))
                ADR_PRESCALE: begin
                    st_d.expo = wr_data[POW_W-1:0];
                    restart   = 1'b1;
                end
                ADR_DIVS: begin
                    st_d.bitn = wr_data[NIB_W-1:0];
                    st_d.pixn = wr_data[2*NIB_W-1:NIB_W];
                    restart   = 1'b1;
                end
                ADR_SOURCE: begin
                    st_d.src = pix_src_e'(wr_data[1:0]);
                    restart  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.expo <= '0;
            st_q.bitn <= NIB_W'(1);
            st_q.pixn <= NIB_W'(1);
            st_q.src  <= SRC_BIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign exp_q     = st_q.expo;
    assign bit_nib_q = st_q.bitn;
    assign pix_nib_q = st_q.pixn;
    assign src_q     = st_q.src;

    // R10: a spare-address write leaves every field untouched
    assert_spare_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ($stable(exp_q) && $stable(bit_nib_q)
                                        && $stable(pix_nib_q) && $stable(src_q)));
endmodule

// File: rtl/pdt_div.sv
module pdt_div #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_ce,
    input  logic [CNT_W-1:0] ratio,
    output logic             out_ce
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    always_comb begin
        wrap   = (cnt_q == CNT_W'(ratio - 1'b1));
        out_ce = rst_n && in_ce && wrap;
        cnt_d  = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (in_ce)
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: above ratio 1 a pulse never lasts two cycles
    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ce && ratio > CNT_W'(1) && !clr) |=> !out_ce);

    // R9: the phase counter stays below the active ratio
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio);
endmodule

// File: rtl/postdiv_ce_tree.sv
module postdiv_ce_tree
    import pdt_pkg::*;
#(
    parameter int POW_W    = 2,
    parameter int NIB_W    = 4,
    parameter int BYTE_DIV = 8,
    parameter int HALF_DIV = 2,
    parameter int QTR_DIV  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [2*NIB_W-1:0] wr_data,
    output logic               stage_ce,
    output logic               bit_ce,
    output logic               byte_ce,
    output logic               pix_ce
);
    localparam int S1_W    = 2 ** POW_W;
    localparam int TAP_MAX = (BYTE_DIV > HALF_DIV)
                           ? ((BYTE_DIV > QTR_DIV) ? BYTE_DIV : QTR_DIV)
                           : ((HALF_DIV > QTR_DIV) ? HALF_DIV : QTR_DIV);
    localparam int TAP_W   = $clog2(TAP_MAX) + 1;
    localparam int NTAPS   = 3;
    localparam int TAP_RATIO [NTAPS] = '{BYTE_DIV, HALF_DIV, QTR_DIV};

    logic [POW_W-1:0] exp_q;
    logic [NIB_W-1:0] bit_nib_q, pix_nib_q;
    pix_src_e         src_q;
    logic             restart;

    logic [S1_W-1:0]  stage_ratio;
    logic [NIB_W-1:0] bit_ratio, pix_ratio;
    logic [NTAPS-1:0] tap_in, tap_out;
    logic             pix_src_ce;

    pdt_cfg_regs #(.POW_W(POW_W), .NIB_W(NIB_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .exp_q(exp_q), .bit_nib_q(bit_nib_q),
        .pix_nib_q(pix_nib_q), .src_q(src_q), .restart(restart)
    );

    always_comb begin
        stage_ratio = S1_W'(1) << exp_q;
        bit_ratio   = (bit_nib_q == '0) ? NIB_W'(1) : bit_nib_q;
        pix_ratio   = (pix_nib_q == '0) ? NIB_W'(1) : pix_nib_q;
    end

    pdt_div #(.CNT_W(S1_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .clr(restart), .in_ce(1'b1),
        .ratio(stage_ratio), .out_ce(stage_ce)
    );

    pdt_div #(.CNT_W(NIB_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .clr(restart), .in_ce(stage_ce),
        .ratio(bit_ratio), .out_ce(bit_ce)
    );

    assign tap_in = {stage_ce, bit_ce, bit_ce};

    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        pdt_div #(.CNT_W(TAP_W)) u_fix (
            .clk(clk), .rst_n(rst_n), .clr(restart), .in_ce(tap_in[t]),
            .ratio(TAP_W'(TAP_RATIO[t])), .out_ce(tap_out[t])
        );
    end

    assign byte_ce = tap_out[0];

    always_comb begin
        unique case (src_q)
            SRC_BIT:      pix_src_ce = bit_ce;
            SRC_BIT_HALF: pix_src_ce = tap_out[1];
            SRC_STAGE:    pix_src_ce = stage_ce;
            default:      pix_src_ce = tap_out[2];
        endcase
    end

    pdt_div #(.CNT_W(NIB_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .clr(restart), .in_ce(pix_src_ce),
        .ratio(pix_ratio), .out_ce(pix_ce)
    );

    // R4: every byte pulse coincides with a bit pulse
    assert_byte_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ce |-> bit_ce);

    // R5: with source 2 a pixel pulse lands on a prescaler pulse
    assert_pix_on_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_STAGE && pix_ce) |-> stage_ce);

    // R3: a bit pulse lands on a prescaler pulse
    assert_bit_on_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ce |-> stage_ce);
endmodule

// File: tb/postdiv_ce_tree_test.sv
`timescale 1ns/1ps
module postdiv_ce_tree_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       stage_ce, bit_ce, byte_ce, pix_ce;

    int n_chk = 0;
    int n_bad = 0;

    int m_first [4];
    int m_second[4];
    int m_after [4];

    always #2.5 clk = ~clk;

    postdiv_ce_tree uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stage_ce(stage_ce), .bit_ce(bit_ce),
        .byte_ce(byte_ce), .pix_ce(pix_ce)
    );

    typedef struct packed {
        logic [1:0]  expo;
        logic [7:0]  divs;
        logic [1:0]  src;
        logic [11:0] p_stage;
        logic [11:0] p_bit;
        logic [11:0] p_byte;
        logic [11:0] p_pix;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h32, 2'd0, 12'd2, 12'd4,   12'd32,  12'd12},
        '{2'd2, 8'h23, 2'd1, 12'd4, 12'd12,  12'd96,  12'd48},
        '{2'd0, 8'h50, 2'd2, 12'd1, 12'd1,   12'd8,   12'd5},
        '{2'd3, 8'h14, 2'd3, 12'd8, 12'd32,  12'd256, 12'd32},
        '{2'd1, 8'h0F, 2'd0, 12'd2, 12'd30,  12'd240, 12'd30},
        '{2'd3, 8'hFF, 2'd0, 12'd8, 12'd120, 12'd960, 12'd1800},
        '{2'd0, 8'h00, 2'd1, 12'd1, 12'd1,   12'd8,   12'd2},
        '{2'd2, 8'h71, 2'd3, 12'd4, 12'd4,   12'd32,  12'd112}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic measure(input int poke);
        for (int s = 0; s < 4; s++) begin
            m_first[s]  = -1;
            m_second[s] = -1;
            m_after[s]  = -1;
        end
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] v;
            bit done;
            wr_en = 1'b0;
            v = {pix_ce, byte_ce, bit_ce, stage_ce};
            for (int s = 0; s < 4; s++) begin
                if (m_first[s] >= 0 && i == m_first[s] + 1) m_after[s] = int'(v[s]);
                if (v[s]) begin
                    if (m_first[s] < 0)       m_first[s]  = i;
                    else if (m_second[s] < 0) m_second[s] = i;
                end
            end
            done = 1'b1;
            for (int s = 0; s < 4; s++) if (m_second[s] < 0) done = 1'b0;
            if (done) break;
            if (i == poke) begin
                wr_addr = 2'd3;
                wr_data = 8'h00;
                wr_en   = 1'b1;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic check_sig(input string tag, input int s, input int p);
        chk({tag, " first pulse index (R9)"}, m_first[s], p - 1);
        chk({tag, " period"}, m_second[s] - m_first[s], p);
        if (p > 1) chk({tag, " one-cycle width (R8)"}, m_after[s], 0);
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: outputs held low in reset
        repeat (3) @(negedge clk);
        chk("R1 stage_ce in reset", int'(stage_ce), 0);
        chk("R1 bit_ce in reset",   int'(bit_ce),   0);
        chk("R1 byte_ce in reset",  int'(byte_ce),  0);
        chk("R1 pix_ce in reset",   int'(pix_ce),   0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: default field values seen through the periods
        measure(-1);
        chk("R1 default stage period", m_second[0] - m_first[0], 1);
        chk("R1 default bit period",   m_second[1] - m_first[1], 1);
        chk("R1 default byte period",  m_second[2] - m_first[2], 8);
        chk("R1 default pix period",   m_second[3] - m_first[3], 1);

        // R2 R3 R4 R5 R6 R7 R9: table walk
        for (int k = 0; k < NV; k++) begin
            wr(2'd0, {6'd0, VECS[k].expo});
            wr(2'd2, {6'd0, VECS[k].src});
            wr(2'd1, VECS[k].divs);
            measure(-1);
            check_sig($sformatf("v%0d stage_ce R2", k),        0, int'(VECS[k].p_stage));
            check_sig($sformatf("v%0d bit_ce R3 R7", k),       1, int'(VECS[k].p_bit));
            check_sig($sformatf("v%0d byte_ce R4", k),         2, int'(VECS[k].p_byte));
            check_sig($sformatf("v%0d pix_ce R5 R6 R7", k),    3, int'(VECS[k].p_pix));
        end

        // R10: spare-address write mid-period leaves phase alone
        wr(2'd0, 8'd3);
        wr(2'd2, 8'd3);
        wr(2'd1, 8'h14);
        measure(100);
        chk("R10 byte first after spare write", m_first[2], 255);
        chk("R10 byte period after spare write", m_second[2] - m_first[2], 256);
        chk("R10 pix period after spare write", m_second[3] - m_first[3], 32);

        // R9: rewriting the same field restarts the phase
        repeat (37) @(negedge clk);
        wr(2'd0, 8'd3);
        measure(-1);
        chk("R9 byte first after same-value rewrite", m_first[2], 255);
        chk("R9 stage first after same-value rewrite", m_first[0], 7);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule